// File: doc/BRIEF.md
# Miss-Dependent Operation Slice Buffer

This block keeps decode moving while a long-latency load miss is outstanding. Once a miss starts, it tracks which architectural registers carry a value derived from the missing load, using one flag per register. Each decoded operation is classified on arrival. An operation that reads a flagged register is parked in an in-order slice buffer, and its destination becomes flagged. An operation that reads no flagged register goes straight to the execute port, and its destination flag is cleared.

When the miss completes, the loaded value is written back on a dedicated port. After that, only the parked operations are replayed to the execute port, one per cycle and in program order. Operations that already executed are never replayed. Decode is stalled while the buffer is full and while the replay is in progress. One miss is handled at a time.

Top module: `miss_slice_buffer`

## Requirements
- R1: After reset, `exec_valid`, `wb_valid` and `stall` are all 0.
- R2: An accepted operation with neither source flagged appears on the execute port in the cycle after acceptance, with `exec_replay`=0 and its own tag and destination.
- R3: An accepted operation that reads the miss destination register produces no execute output and is parked.
- R4: Dependence is transitive. An operation reading the destination of a parked operation is also parked.
- R5: An independent operation that writes a flagged register clears that flag. A later reader of that register then executes immediately.
- R6: One cycle after `miss_done` is accepted, `wb_valid` is 1 with `wb_dst` equal to the miss register and `wb_data` equal to `miss_data`. This happens one cycle before the first replay.
- R7: Parked operations replay with `exec_replay`=1, one per cycle, in their original order. The first replay comes two cycles after `miss_done`. No independent operation is replayed.
- R8: When the buffer holds DEPTH operations, `stall` is 1. An operation offered during a stall is neither executed nor buffered.
- R9: `stall` is 1 for the whole replay and returns to 0 in the cycle the last replay appears.
- R10: A `miss_start` while a miss is already outstanding is ignored. Its register is not flagged, and the writeback names the first miss register.
- R11: A miss that completes with nothing parked produces the writeback only, with no replay and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is offered |
| op_dst | input | REG_W | Destination register of the operation |
| op_src_a | input | REG_W | First source register |
| op_src_b | input | REG_W | Second source register |
| op_tag | input | TAG_W | Identifier carried with the operation |
| stall | output | 1 | Decode must hold; the offered operation is not taken |
| miss_start | input | 1 | A load has missed; accepted only when no miss is outstanding |
| miss_dst | input | REG_W | Destination register of the missing load |
| miss_done | input | 1 | The missing data has arrived |
| miss_data | input | DATA_W | The arrived load value |
| exec_valid | output | 1 | An operation is issued to execution |
| exec_replay | output | 1 | The issued operation comes from the slice buffer |
| exec_dst | output | REG_W | Destination of the issued operation |
| exec_tag | output | TAG_W | Tag of the issued operation |
| wb_valid | output | 1 | Load result writeback |
| wb_dst | output | REG_W | Register receiving the load result |
| wb_data | output | DATA_W | Load result value |

## Verification
Each result has a fixed delay after its stimulus:
- An independent operation shows on the execute port one edge after it is accepted.
- The writeback shows one edge after `miss_done`.
- The k-th replay shows k+1 edges after `miss_done`.
- `stall` follows the registered state, so it changes on the same edge that moves the block into or out of replay.

Inputs are applied after a falling edge. Every output is sampled shortly after the next rising edge, so each check looks at exactly the one cycle in which its result is due. Quiet cycles are checked too, to show that parked or refused operations produce nothing there.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_DRAIN = 2'd2
  } slice_state_e;
endpackage

// File: rtl/slice_dep_track.sv
module slice_dep_track #(
  parameter int NREG = 8,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             miss_set,
  input  logic [REG_W-1:0] miss_reg,
  input  logic             op_en,
  input  logic [REG_W-1:0] op_src_a,
  input  logic [REG_W-1:0] op_src_b,
  input  logic [REG_W-1:0] op_dst,
  output logic             op_dep,
  output logic [NREG-1:0]  dep_bits
);
  logic [NREG-1:0] dep_q, dep_d;

  assign op_dep   = dep_q[op_src_a] | dep_q[op_src_b];
  assign dep_bits = dep_q;

  always_comb begin
    dep_d = dep_q;
    if (clear_all) begin
      dep_d = '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (op_en && (op_dst == REG_W'(r))) dep_d[r] = op_dep;
        if (miss_set && (miss_reg == REG_W'(r))) dep_d[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dep_q <= '0;
    else        dep_q <= dep_d;
  end
endmodule

// File: rtl/slice_fifo.sv
module slice_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         miss_start,
  input  logic         miss_done,
  input  logic         level_zero_next,
  output slice_state_e state
);
  slice_state_e st_q, st_d;

  assign state = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (miss_start) st_d = ST_MISS;
      ST_MISS:  if (miss_done)  st_d = level_zero_next ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (level_zero_next) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/miss_slice_buffer.sv
module miss_slice_buffer
  import slice_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [REG_W-1:0]  op_dst,
  input  logic [REG_W-1:0]  op_src_a,
  input  logic [REG_W-1:0]  op_src_b,
  input  logic [TAG_W-1:0]  op_tag,
  output logic              stall,
  input  logic              miss_start,
  input  logic [REG_W-1:0]  miss_dst,
  input  logic              miss_done,
  input  logic [DATA_W-1:0] miss_data,
  output logic              exec_valid,
  output logic              exec_replay,
  output logic [REG_W-1:0]  exec_dst,
  output logic [TAG_W-1:0]  exec_tag,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data
);
  localparam int ENT_W = REG_W + TAG_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  slice_state_e     state;
  logic             accept, op_dep, push, pop, miss_set, done_acc;
  logic             fifo_full, fifo_empty, level_zero_next;
  logic [ENT_W-1:0] head;
  logic [CNT_W-1:0] count, level_next;
  logic [NREG-1:0]  dep_bits;
  logic [REG_W-1:0] miss_reg_q, miss_reg_d;

  logic              ex_v_d, ex_rp_d;
  logic [REG_W-1:0]  ex_dst_d;
  logic [TAG_W-1:0]  ex_tag_d;
  logic              wb_v_d;
  logic [REG_W-1:0]  wb_dst_d;
  logic [DATA_W-1:0] wb_data_d;

  assign stall    = fifo_full | (state == ST_DRAIN);
  assign accept   = op_valid & ~stall;
  assign push     = accept & op_dep;
  assign pop      = (state == ST_DRAIN) & ~fifo_empty;
  assign miss_set = miss_start & (state == ST_IDLE);
  assign done_acc = miss_done & (state == ST_MISS);

  assign level_next      = count + CNT_W'(push) - CNT_W'(pop);
  assign level_zero_next = (level_next == '0);

  slice_dep_track #(.NREG(NREG)) u_dep (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_all(done_acc),
    .miss_set (miss_set),
    .miss_reg (miss_dst),
    .op_en    (accept),
    .op_src_a (op_src_a),
    .op_src_b (op_src_b),
    .op_dst   (op_dst),
    .op_dep   (op_dep),
    .dep_bits (dep_bits)
  );

  slice_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data({op_dst, op_tag}),
    .pop      (pop),
    .head     (head),
    .count    (count),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  slice_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_start     (miss_set),
    .miss_done      (miss_done),
    .level_zero_next(level_zero_next),
    .state          (state)
  );

  always_comb begin
    miss_reg_d = miss_set ? miss_dst : miss_reg_q;
    ex_v_d     = pop | (accept & ~op_dep);
    ex_rp_d    = pop;
    if (pop) begin
      ex_dst_d = head[ENT_W-1:TAG_W];
      ex_tag_d = head[TAG_W-1:0];
    end else begin
      ex_dst_d = op_dst;
      ex_tag_d = op_tag;
    end
    wb_v_d    = done_acc;
    wb_dst_d  = done_acc ? miss_reg_q : wb_dst;
    wb_data_d = done_acc ? miss_data : wb_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_reg_q  <= '0;
      exec_valid  <= 1'b0;
      exec_replay <= 1'b0;
      exec_dst    <= '0;
      exec_tag    <= '0;
      wb_valid    <= 1'b0;
      wb_dst      <= '0;
      wb_data     <= '0;
    end else begin
      miss_reg_q  <= miss_reg_d;
      exec_valid  <= ex_v_d;
      exec_replay <= ex_rp_d;
      if (ex_v_d) begin
        exec_dst <= ex_dst_d;
        exec_tag <= ex_tag_d;
      end
      wb_valid <= wb_v_d;
      wb_dst   <= wb_dst_d;
      wb_data  <= wb_data_d;
    end
  end

  AST_WB_BEFORE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_replay && !$past(exec_valid && exec_replay)) |-> $past(wb_valid)); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && stall) |=> !(exec_valid && !exec_replay)); // R8
  AST_REPLAY_ONLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_replay) |-> $past(state == ST_DRAIN)); // R7
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (dep_bits == '0)); // R11
endmodule

// File: tb/test_miss_slice_buffer.sv
module test_miss_slice_buffer;
  localparam int NREG = 8, TAG_W = 8, DATA_W = 16, DEPTH = 4;
  localparam int REG_W = $clog2(NREG);
  localparam int NROWS = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, miss_start = 1'b0, miss_done = 1'b0;
  logic [REG_W-1:0] op_dst = '0, op_src_a = '0, op_src_b = '0, miss_dst = '0;
  logic [TAG_W-1:0] op_tag = '0;
  logic [DATA_W-1:0] miss_data = '0;
  logic stall, exec_valid, exec_replay, wb_valid;
  logic [REG_W-1:0] exec_dst, wb_dst;
  logic [TAG_W-1:0] exec_tag;
  logic [DATA_W-1:0] wb_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  miss_slice_buffer #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_miss_slice_buffer (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dst(op_dst),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_tag(op_tag), .stall(stall),
    .miss_start(miss_start), .miss_dst(miss_dst), .miss_done(miss_done),
    .miss_data(miss_data), .exec_valid(exec_valid), .exec_replay(exec_replay),
    .exec_dst(exec_dst), .exec_tag(exec_tag), .wb_valid(wb_valid),
    .wb_dst(wb_dst), .wb_data(wb_data)
  );

  // row: ov ms md dst s1 s2 tag | exp: ev rp etag wb stall
  function automatic logic [31:0] mk(input bit ov, input bit ms, input bit md,
      input int dst, input int s1, input int s2, input int tag,
      input bit ev, input bit rp, input int etag, input bit wb, input bit st);
    return {ov, ms, md, 3'(dst), 3'(s1), 3'(s2), 8'(tag), ev, rp, 8'(etag), wb, st};
  endfunction

  localparam logic [31:0] TABLE [NROWS] = '{
    mk(1,0,0, 1,2,3, 10, 1,0,10, 0,0),  // R2 independent, no miss
    mk(0,1,0, 2,0,0,  0, 0,0, 0, 0,0),  // miss on r2
    mk(1,0,0, 3,2,0, 11, 0,0, 0, 0,0),  // R3 reads r2 -> parked
    mk(1,0,0, 4,3,1, 12, 0,0, 0, 0,0),  // R4 transitive via r3
    mk(1,0,0, 5,1,0, 13, 1,0,13, 0,0),  // R2 independent during miss
    mk(1,0,0, 3,1,1, 14, 1,0,14, 0,0),  // R5 independent write of r3
    mk(1,0,0, 6,3,0, 15, 1,0,15, 0,0),  // R5 r3 now clean
    mk(1,0,0, 7,4,0, 16, 0,0, 0, 0,0),  // R4 r4 still flagged
    mk(0,0,1, 0,0,0,  0, 0,0, 0, 1,1),  // R6 writeback, R9 stall
    mk(0,0,0, 0,0,0,  0, 1,1,11, 0,1),  // R7 first replay
    mk(0,0,0, 0,0,0,  0, 1,1,12, 0,1),  // R7
    mk(0,0,0, 0,0,0,  0, 1,1,16, 0,0),  // R7 last, R9 stall drops
    mk(0,0,0, 0,0,0,  0, 0,0, 0, 0,0),  // R7 nothing more replayed
    mk(1,0,0, 2,2,2, 20, 1,0,20, 0,0)   // R2 r2 clean after miss
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit ov, input bit ms, input bit md, input int dst,
                      input int s1, input int s2, input int tag, input int data);
    @(negedge clk);
    op_valid = ov; miss_start = ms; miss_done = md;
    op_dst = REG_W'(dst); op_src_a = REG_W'(s1); op_src_b = REG_W'(s2);
    miss_dst = REG_W'(dst); op_tag = TAG_W'(tag); miss_data = DATA_W'(data);
    @(posedge clk);
    #2;
    op_valid = 0; miss_start = 0; miss_done = 0;
  endtask

  task automatic expect_exec(input string req, input bit ev, input bit rp, input int tag);
    chk(exec_valid == ev, req, int'(exec_valid), int'(ev));
    if (ev) begin
      chk(exec_replay == rp, req, int'(exec_replay), int'(rp));
      chk(exec_tag == TAG_W'(tag), req, int'(exec_tag), tag);
    end
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(exec_valid == 0, "R1 exec_valid", int'(exec_valid), 0);
    chk(wb_valid == 0, "R1 wb_valid", int'(wb_valid), 0);
    chk(stall == 0, "R1 stall", int'(stall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      logic [31:0] v;
      v = TABLE[i];
      step(v[31], v[30], v[29], int'(v[28:26]), int'(v[25:23]), int'(v[22:20]),
           int'(v[19:12]), 16'h1234);
      expect_exec($sformatf("table row %0d (R2 R3 R4 R5 R7)", i), v[11], v[10], int'(v[9:2]));
      chk(wb_valid == v[1], $sformatf("table row %0d wb (R6)", i), int'(wb_valid), int'(v[1]));
      chk(stall == v[0], $sformatf("table row %0d stall (R9)", i), int'(stall), int'(v[0]));
    end

    // R8: fill the buffer, offer ops during stall
    step(0,1,0, 1,0,0, 0, 0);
    for (int k = 0; k < DEPTH; k++) begin
      step(1,0,0, 2,1,1, 30 + k, 0);
      expect_exec("R8 fill parks", 0, 0, 0);
    end
    chk(stall == 1, "R8 stall when full", int'(stall), 1);
    step(1,0,0, 2,1,1, 34, 0);
    expect_exec("R8 dependent op during stall", 0, 0, 0);
    step(1,0,0, 3,0,0, 35, 0);
    expect_exec("R8 independent op during stall", 0, 0, 0);
    step(0,0,1, 0,0,0, 0, 16'hBEEF);
    chk(wb_valid == 1, "R6 wb_valid", int'(wb_valid), 1);
    chk(wb_dst == 1, "R6 wb_dst", int'(wb_dst), 1);
    chk(wb_data == 16'hBEEF, "R6 wb_data", int'(wb_data), 16'hBEEF);
    chk(exec_valid == 0, "R6 no replay with writeback", int'(exec_valid), 0);
    for (int k = 0; k < DEPTH; k++) begin
      step(0,0,0, 0,0,0, 0, 0);
      expect_exec("R7 replay order", 1, 1, 30 + k);
      chk(exec_dst == 2, "R7 replay dst", int'(exec_dst), 2);
      chk(stall == (k != DEPTH - 1), "R9 stall during replay", int'(stall), int'(k != DEPTH - 1));
    end
    step(0,0,0, 0,0,0, 0, 0);
    expect_exec("R8 refused op not buffered", 0, 0, 0);

    // R10: second miss_start ignored
    step(0,1,0, 5,0,0, 0, 0);
    step(0,1,0, 6,0,0, 0, 0);
    step(1,0,0, 7,6,6, 40, 0);
    expect_exec("R10 second miss reg not flagged", 1, 0, 40);
    step(1,0,0, 7,5,0, 41, 0);
    expect_exec("R10 first miss reg flagged", 0, 0, 0);
    step(0,0,1, 0,0,0, 0, 16'h0077);
    chk(wb_dst == 5, "R10 wb_dst keeps first miss", int'(wb_dst), 5);
    step(0,0,0, 0,0,0, 0, 0);
    expect_exec("R10 replay of parked op", 1, 1, 41);

    // R11: miss with nothing parked
    step(0,1,0, 7,0,0, 0, 0);
    step(0,0,1, 0,0,0, 0, 16'h0042);
    chk(wb_valid == 1 && wb_dst == 7, "R11 writeback only", int'(wb_dst), 7);
    chk(stall == 0, "R11 no stall", int'(stall), 0);
    step(0,0,0, 0,0,0, 0, 0);
    expect_exec("R11 no replay", 0, 0, 0);
    chk(stall == 0, "R11 idle after", int'(stall), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule